// File: doc/BRIEF.md
# Sequential 16-bit Multiplier with Status Flags

This block multiplies two operands of a 16-bit integer datapath and produces the arithmetic status flags that such a datapath expects from a multiply. A two-bit mode input chooses one of three forms. The unsigned widening form returns the full double-width product as a low and a high half. The signed widening form treats both operands as two's complement and returns the full signed product. The signed truncating form keeps only the low half; the two- and three-operand multiply variants use it, and the operand that might come from an immediate arrives on the ordinary operand input.

The datapath takes its operands on a start strobe. It multiplies their magnitudes with a shift-add loop that handles one multiplier bit per clock, and it restores the sign in a final cycle. Result halves and flags are registered together and then held. A one-cycle done pulse marks their arrival. Decoding, register-file access and immediate fetch happen outside the block.

Top module: `mulu16`

## Requirements
- R1: Mode code 0 (and the spare code 3, which acts the same) multiplies unsigned: `res_lo_o` carries the low W bits and `res_hi_o` the high W bits of the zero-extended 2W-bit product.
- R2: Mode code 1 multiplies both operands as two's complement and returns the full 2W-bit signed product, low half on `res_lo_o` and high half on `res_hi_o`.
- R3: Mode code 2 returns the low W bits of the signed product on `res_lo_o` and drives `res_hi_o` to zero.
- R4: `sf_o` equals the top bit of `res_lo_o`, and `zf_o` is 1 exactly when `res_lo_o` is zero. `pf_o` is 1 when the low 8 bits of `res_lo_o` hold an even number of ones; when W is below 8, all W bits are counted.
- R5: In the unsigned modes, `cf_o` and `of_o` are both 1 exactly when the high half of the product is nonzero.
- R6: In both signed modes, `cf_o` and `of_o` are both 1 exactly when the 2W-bit signed product differs from the sign extension of its low W bits.
- R7: `af_o` is always 0.
- R8: `done_o` goes high for exactly one cycle. It rises W+1 clock edges after the edge that accepted the start, and the results and flags are valid in that same cycle.
- R9: The results and flags change only in the cycle where `done_o` is high. At all other times they keep their last values.
- R10: A start that arrives while an operation is in progress is ignored. It does not alter the running result and does not produce an extra done pulse.
- R11: After a synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| mode_i | input | 2 | 0/3 unsigned widening, 1 signed widening, 2 signed truncating |
| opa_i | input | W (16) | First operand |
| opb_i | input | W (16) | Second operand (register or immediate) |
| res_lo_o | output | W (16) | Low half of the product |
| res_hi_o | output | W (16) | High half of the product, zero in truncating mode |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag |
| af_o | output | 1 | Auxiliary flag, always 0 |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The bench builds the block with W set to 5. At that width every operand pair in every mode code, 4096 operations in all, runs in a few tens of thousands of cycles. The sweep reaches every sign combination, the most negative operand times itself and times minus one, all-ones unsigned operands, and every boundary where a product stops fitting its sign-extended low half. With a 5-bit result, the parity rule also counts all result bits.

// File: rtl/mulu_pkg.sv
package mulu_pkg;

  typedef enum logic [1:0] {
    MD_UNS     = 2'd0,
    MD_SWIDE   = 2'd1,
    MD_STRUNC  = 2'd2,
    MD_UNS_ALT = 2'd3
  } mulu_mode_e;

  // Signed forms are the widening and the truncating signed codes.
  function automatic logic mode_is_signed(input mulu_mode_e m);
    return (m == MD_SWIDE) || (m == MD_STRUNC);
  endfunction

  function automatic logic mode_is_trunc(input mulu_mode_e m);
    return m == MD_STRUNC;
  endfunction

  // Even parity over one byte: 1 when the count of ones is even.
  function automatic logic even_parity8(input logic [7:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/mulu_seq.sv
module mulu_seq #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic step_o,
  output logic fin_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seq_state_e;

  seq_state_e     state_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_RUN;
          cnt_q   <= '0;
        end
        S_RUN: begin
          if (cnt_q == LAST) state_q <= S_FIN;
          else               cnt_q   <= cnt_q + CW'(1);
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign accept_o = start_i && (state_q == S_IDLE);
  assign busy_o   = (state_q != S_IDLE);
  assign step_o   = (state_q == S_RUN);
  assign fin_o    = (state_q == S_FIN);

endmodule

// File: rtl/mulu_core.sv
module mulu_core
  import mulu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [1:0]        mode_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  output logic [2*W-1:0]    prod_o,
  output mulu_mode_e        mode_q_o
);
  localparam int PW = 2 * W;

  logic [W-1:0] mcand_q, hiacc_q, mplr_q;
  logic         neg_q;
  mulu_mode_e   mode_q;

  mulu_mode_e   mode_in;
  logic         sgn_in;
  logic [W-1:0] amag, bmag;
  logic [W:0]   sum;
  logic [PW-1:0] raw;

  always_comb begin
    mode_in = mulu_mode_e'(mode_i);
    sgn_in  = mode_is_signed(mode_in);
    amag    = (sgn_in && opa_i[W-1]) ? (~opa_i + W'(1)) : opa_i;
    bmag    = (sgn_in && opb_i[W-1]) ? (~opb_i + W'(1)) : opb_i;
    sum     = {1'b0, hiacc_q} + (mplr_q[0] ? {1'b0, mcand_q} : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      hiacc_q <= '0;
      mplr_q  <= '0;
      neg_q   <= 1'b0;
      mode_q  <= MD_UNS;
    end else if (load_i) begin
      mcand_q <= amag;
      mplr_q  <= bmag;
      hiacc_q <= '0;
      neg_q   <= sgn_in && (opa_i[W-1] ^ opb_i[W-1]);
      mode_q  <= mode_in;
    end else if (step_i) begin
      hiacc_q <= sum[W:1];
      mplr_q  <= {sum[0], mplr_q[W-1:1]};
    end
  end

  assign raw      = {hiacc_q, mplr_q};
  assign prod_o   = neg_q ? (~raw + PW'(1)) : raw;
  assign mode_q_o = mode_q;

endmodule

// File: rtl/mulu_flags.sv
module mulu_flags
  import mulu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2*W-1:0] prod_i,
  input  mulu_mode_e     mode_i,
  output logic [W-1:0]   lo_o,
  output logic [W-1:0]   hi_o,
  output logic           ovf_o,
  output logic           sf_o,
  output logic           zf_o,
  output logic           pf_o
);
  localparam int PB = (W < 8) ? W : 8;

  logic [W-1:0] lo, hi;
  logic [7:0]   pbyte;

  always_comb begin
    lo    = prod_i[W-1:0];
    hi    = prod_i[2*W-1:W];
    pbyte = '0;
    pbyte[PB-1:0] = lo[PB-1:0];
    if (mode_is_signed(mode_i)) ovf_o = (hi != {W{lo[W-1]}});
    else                        ovf_o = (hi != '0);
    lo_o = lo;
    hi_o = mode_is_trunc(mode_i) ? '0 : hi;
    sf_o = lo[W-1];
    zf_o = (lo == '0);
    pf_o = even_parity8(pbyte);
  end

endmodule

// File: rtl/mulu16.sv
module mulu16
  import mulu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] res_lo_o,
  output logic [W-1:0] res_hi_o,
  output logic         cf_o,
  output logic         of_o,
  output logic         sf_o,
  output logic         zf_o,
  output logic         pf_o,
  output logic         af_o,
  output logic         done_o
);
  // Named internal events, visible to the bound checker.
  logic           accept, busy, step, fin;
  logic [2*W-1:0] prod;
  mulu_mode_e     mode_q;
  logic [W-1:0]   f_lo, f_hi;
  logic           f_ovf, f_sf, f_zf, f_pf;

  mulu_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i),
    .accept_o(accept), .busy_o(busy), .step_o(step), .fin_o(fin)
  );

  mulu_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .load_i(accept), .step_i(step),
    .mode_i(mode_i), .opa_i(opa_i), .opb_i(opb_i),
    .prod_o(prod), .mode_q_o(mode_q)
  );

  mulu_flags #(.W(W)) u_flags (
    .prod_i(prod), .mode_i(mode_q),
    .lo_o(f_lo), .hi_o(f_hi), .ovf_o(f_ovf),
    .sf_o(f_sf), .zf_o(f_zf), .pf_o(f_pf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_lo_o <= '0;
      res_hi_o <= '0;
      cf_o     <= 1'b0;
      of_o     <= 1'b0;
      sf_o     <= 1'b0;
      zf_o     <= 1'b0;
      pf_o     <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) begin
        res_lo_o <= f_lo;
        res_hi_o <= f_hi;
        cf_o     <= f_ovf;
        of_o     <= f_ovf;
        sf_o     <= f_sf;
        zf_o     <= f_zf;
        pf_o     <= f_pf;
      end
    end
  end

  assign af_o = 1'b0;

endmodule

// File: rtl/mulu16_chk.sv
module mulu16_chk
  import mulu_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         accept,
  input logic         busy,
  input mulu_mode_e   mode_q,
  input logic [W-1:0] res_lo_o,
  input logic [W-1:0] res_hi_o,
  input logic         cf_o,
  input logic         of_o,
  input logic         zf_o,
  input logic         af_o,
  input logic         done_o
);
  localparam int LW = $clog2(W + 4) + 1;
  localparam logic [LW-1:0] DONE_AT = LW'(W + 2);

  logic [LW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst)                lat_q <= '0;
    else if (accept)        lat_q <= LW'(1);
    else if (done_o)        lat_q <= '0;
    else if (lat_q != '0)   lat_q <= lat_q + LW'(1);
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat_q == DONE_AT));

  // R9
  hold_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_lo_o) |-> done_o);

  // R9
  hold_hi_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_hi_o) |-> done_o);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !accept);

  // R7
  aux_zero_chk: assert property (@(posedge clk) disable iff (rst)
    af_o == 1'b0);

  // R3
  trunc_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q == MD_STRUNC) |-> (res_hi_o == '0));

  // R5
  uns_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !mode_is_signed(mode_q)) |-> (cf_o == (res_hi_o != '0)));

  // R6
  swide_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q == MD_SWIDE) |-> (cf_o == (res_hi_o != {W{res_lo_o[W-1]}})));

  // R5
  cf_of_equal_chk: assert property (@(posedge clk) disable iff (rst)
    cf_o == of_o);

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (zf_o == (res_lo_o == '0)));

endmodule

bind mulu16 mulu16_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .busy(busy), .mode_q(mode_q),
  .res_lo_o(res_lo_o), .res_hi_o(res_hi_o), .cf_o(cf_o), .of_o(of_o),
  .zf_o(zf_o), .af_o(af_o), .done_o(done_o)
);

// File: tb/tb_mulu16.sv
`timescale 1ns/1ps
module tb_mulu16;
  localparam int W    = 5;
  localparam int FULL = 1 << W;
  localparam int HALF = 1 << (W - 1);
  localparam int MASK = FULL - 1;
  localparam int PB   = (W < 8) ? W : 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] mode = '0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] res_lo, res_hi;
  logic cf, of_f, sf, zf, pf, af, done;

  int total = 0;
  int fails = 0;
  int lat;

  always #2.5 clk = ~clk;

  mulu16 #(.W(W)) dut (
    .clk(clk), .rst(rst), .start_i(start), .mode_i(mode),
    .opa_i(opa), .opb_i(opb), .res_lo_o(res_lo), .res_hi_o(res_hi),
    .cf_o(cf), .of_o(of_f), .sf_o(sf), .zf_o(zf), .pf_o(pf),
    .af_o(af), .done_o(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // Expected results from the arithmetic definition of each mode.
  task automatic expect_op(input int m, input int a, input int b,
                           output int elo, output int ehi, output int eovf,
                           output int esf, output int ezf, output int epf);
    int sa, sb, p, los, ones;
    bit sgn;
    sgn = (m == 1) || (m == 2);
    sa  = (a >= HALF) ? a - FULL : a;
    sb  = (b >= HALF) ? b - FULL : b;
    p   = sgn ? sa * sb : a * b;
    elo = p & MASK;
    ehi = (m == 2) ? 0 : ((p >>> W) & MASK);
    los = (elo >= HALF) ? elo - FULL : elo;
    eovf = sgn ? int'(p != los) : int'((p >>> W) != 0);
    esf = (elo >> (W - 1)) & 1;
    ezf = int'(elo == 0);
    ones = 0;
    for (int i = 0; i < PB; i++) ones += (elo >> i) & 1;
    epf = int'((ones % 2) == 0);
  endtask

  // Launch one operation; optionally pulse start again while busy.
  task automatic run_op(input int m, input int a, input int b, input bit inject,
                        output int latency);
    @(negedge clk);
    start = 1'b1; mode = 2'(m); opa = W'(a); opb = W'(b);
    @(negedge clk);
    start = 1'b0;
    latency = 0;
    do begin
      @(negedge clk);
      latency++;
      if (inject && latency == 2) begin
        start = 1'b1; mode = 2'd2; opa = W'(b + 1); opb = W'(a + 3);
      end else begin
        start = 1'b0;
      end
    end while (!done && latency < W + 10);
    start = 1'b0;
  endtask

  task automatic verify(input int m, input int a, input int b, input int latency);
    int elo, ehi, eovf, esf, ezf, epf;
    string rq;
    expect_op(m, a, b, elo, ehi, eovf, esf, ezf, epf);
    rq = (m == 1) ? "R2" : (m == 2) ? "R3" : "R1";
    check(rq, "low result", int'(res_lo), elo);
    check(rq, "high result", int'(res_hi), ehi);
    check((m == 1 || m == 2) ? "R6" : "R5", "carry", int'(cf), eovf);
    check((m == 1 || m == 2) ? "R6" : "R5", "overflow", int'(of_f), eovf);
    check("R4", "sign", int'(sf), esf);
    check("R4", "zero", int'(zf), ezf);
    check("R4", "parity", int'(pf), epf);
    check("R7", "aux", int'(af), 0);
    check("R8", "latency", latency, W + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int l;
    logic [W-1:0] keep_lo;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset values
    check("R11", "reset outputs",
          int'({res_lo, res_hi, cf, of_f, sf, zf, pf, af, done}), 0);

    // Exhaustive sweep of every mode code and operand pair.
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < FULL; a++)
        for (int b = 0; b < FULL; b++) begin
          run_op(m, a, b, 1'b0, l);
          verify(m, a, b, l);
          @(negedge clk);
          check("R8", "done width", int'(done), 0);
        end

    // R10: start pulsed while busy is ignored; R9: outputs then hold.
    run_op(0, 7, 9, 1'b1, l);
    verify(0, 7, 9, l);
    keep_lo = res_lo;
    for (int k = 0; k < W + 4; k++) begin
      @(negedge clk);
      check("R10", "extra done", int'(done), 0);
      check("R9", "held low result", int'(res_lo), int'(keep_lo));
    end

    run_op(1, HALF, HALF, 1'b1, l);
    verify(1, HALF, HALF, l);
    for (int k = 0; k < W + 4; k++) begin
      @(negedge clk);
      check("R10", "extra done after signed op", int'(done), 0);
    end

    // R9: changing inputs without start leaves outputs alone.
    keep_lo = res_lo;
    mode = 2'd0; opa = '1; opb = '1;
    repeat (W + 3) @(negedge clk);
    check("R9", "idle inputs change", int'(res_lo), int'(keep_lo));

    summary();
    $finish;
  end

endmodule